// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns addresses that arrive from a PCI bus for DMA into host physical addresses. Four programmable windows are held on chip. Each window has three registers: a window base, a window mask and a translated base. A request is checked against the windows from index 0 upward, and the lowest enabled window that matches handles it. That window maps the address in one of two ways. In direct mode the translated base supplies the upper bits and the bus address keeps an offset whose width depends on the mask. In scatter-gather mode the block reads a 64-bit page table entry from memory, and the entry supplies the page frame.

Software programs the windows through a simple register port. A write takes effect on the next clock edge. A read returns data in the same cycle. Translation uses a valid/ready request and a one-cycle response pulse. The response carries the physical address, a hit flag and the index of the winning window. Page table entries are fetched through a separate 64-bit read port. Its request uses valid/ready and its data return is a valid pulse.

Top module: `dma_window_xlat`

## Requirements
- R1: After reset, all twelve window registers read as zero, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: `reg_addr[3:2]` selects the register kind: 0 for window base, 1 for window mask, 2 for translated base. `reg_addr[1:0]` selects the window. A written value reads back unchanged. Kind 3 reads as zero and ignores writes.
- R3: The compare field is address bits 31:20. A window matches when the bus address and the window base agree on every field bit that is clear in the window mask. No other bits take part in the compare.
- R4: Window base bit 0 enables the window. A matching window that is not enabled is passed over. Among the enabled windows that match, the lowest index wins, and that index is returned on `rsp_win`.
- R5: Window base bit 1 clear selects direct mode. Let O be (mask AND 0xFFF00000) OR 0xFFFFF. The result is (translated base AND NOT O) OR (bus address AND O).
- R6: Window base bit 1 set selects scatter-gather mode. Let F be mask AND 0xFFF00000. The entry address is (translated base AND NOT((F >> 10) OR 0x3FF)) OR ((bus address AND (F OR 0xFE000)) >> 10). This address appears on `mem_req_addr`.
- R7: In scatter-gather mode the result is ((entry with bit 0 cleared) << 12) OR (bus address AND 0x1FFF).
- R8: Every result produced by a hit is truncated to 34 bits, so `rsp_addr[63:34]` is zero whenever `rsp_hit` is 1.
- R9: When no enabled window matches, `rsp_hit` is 0, `rsp_win` is 0, and `rsp_addr` equals the full 64-bit bus address.
- R10: A request that is a miss or a direct-mode hit is answered by a one-cycle `rsp_valid` in the cycle after it is accepted.
- R11: While a page table fetch is outstanding, `req_ready` is 0 and no response is given. The response comes in the cycle after `mem_rsp_valid`.
- R12: The window registers are sampled when a request is accepted. A register write made while that translation is in flight affects only later requests.
- R13: `mem_req_valid` stays high, with `mem_req_addr` stable, until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select: {kind, window} |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr`, same cycle |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_hit | output | 1 | An enabled window matched |
| rsp_win | output | 2 | Index of the winning window |
| mem_req_valid | output | 1 | Page table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 64 | Page table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Page table entry |

## Verification
Two cases are hard to reach from the ports. The first is a register write that lands while a scatter-gather fetch is outstanding. The bench creates it by holding `mem_req_ready` low for one cycle and rewriting the winning window's translated base during that stall. It then expects the old mapping for the in-flight request and the new mapping for the next request. The second is priority among overlapping windows. The bench sweeps all 4096 values of bits 31:20 against two window layouts. One layout has a disabled window, a window hidden behind a lower index, and a window that is exposed once the lower one is disabled. Expected results come from an arithmetic model that runs alongside, and the page table memory returns a computed function of the entry address.

// File: rtl/dwx_pkg.sv
package dwx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } xlat_st_e;

    localparam logic [1:0] KIND_BASE  = 2'd0;
    localparam logic [1:0] KIND_MASK  = 2'd1;
    localparam logic [1:0] KIND_XBASE = 2'd2;

    localparam int EN_BIT      = 0;
    localparam int SG_BIT      = 1;
    localparam int FIELD_LSB   = 20;
    localparam int FIELD_MSB   = 31;
    localparam int PAGE_LSB    = 13;
    localparam int PTE_SHR     = 10;
    localparam int FRAME_SHL   = 12;

endpackage

// File: rtl/dwx_regfile.sv
module dwx_regfile
    import dwx_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int AW   = 64,
    parameter int IW   = $clog2(NWIN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IW+1:0]             addr,
    input  logic [AW-1:0]             wdata,
    output logic [AW-1:0]             rdata,
    output logic [NWIN-1:0][AW-1:0]   base_o,
    output logic [NWIN-1:0][AW-1:0]   mask_o,
    output logic [NWIN-1:0][AW-1:0]   xbase_o
);

    typedef struct packed {
        logic [NWIN-1:0][AW-1:0] base;
        logic [NWIN-1:0][AW-1:0] mask;
        logic [NWIN-1:0][AW-1:0] xbase;
    } regs_t;

    regs_t r_d, r_q;
    logic [1:0]    kind;
    logic [IW-1:0] idx;

    assign kind = addr[IW+1:IW];
    assign idx  = addr[IW-1:0];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (kind)
                KIND_BASE:  r_d.base[idx]  = wdata;
                KIND_MASK:  r_d.mask[idx]  = wdata;
                KIND_XBASE: r_d.xbase[idx] = wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (kind)
            KIND_BASE:  rdata = r_q.base[idx];
            KIND_MASK:  rdata = r_q.mask[idx];
            KIND_XBASE: rdata = r_q.xbase[idx];
            default:    rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base_o  = r_q.base;
    assign mask_o  = r_q.mask;
    assign xbase_o = r_q.xbase;

endmodule

// File: rtl/dwx_match.sv
module dwx_match
    import dwx_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int AW   = 64,
    parameter int IW   = $clog2(NWIN)
) (
    input  logic [AW-1:0]            bus,
    input  logic [NWIN-1:0][AW-1:0]  base,
    input  logic [NWIN-1:0][AW-1:0]  mask,
    input  logic [NWIN-1:0][AW-1:0]  xbase,
    output logic                     hit,
    output logic [IW-1:0]            win,
    output logic                     sg,
    output logic [AW-1:0]            dir_addr,
    output logic [AW-1:0]            pte_addr
);

    localparam logic [AW-1:0] ONE      = AW'(1);
    localparam logic [AW-1:0] FIELD    = ((ONE << (FIELD_MSB + 1)) - ONE) & ~((ONE << FIELD_LSB) - ONE);
    localparam logic [AW-1:0] OFF_LOW  = (ONE << FIELD_LSB) - ONE;
    localparam logic [AW-1:0] SEL_LOW  = ((ONE << FIELD_LSB) - ONE) & ~((ONE << PAGE_LSB) - ONE);
    localparam logic [AW-1:0] TBL_LOW  = (ONE << PTE_SHR) - ONE;

    logic [NWIN-1:0]         hit_v;
    logic [NWIN-1:0][AW-1:0] dir_v;
    logic [NWIN-1:0][AW-1:0] pte_v;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [AW-1:0] fld, cmp, off, sel, tbm;
        assign fld = mask[w] & FIELD;
        assign cmp = ~mask[w] & FIELD;
        assign hit_v[w] = base[w][EN_BIT] && (((bus ^ base[w]) & cmp) == '0);
        assign off = fld | OFF_LOW;
        assign dir_v[w] = (xbase[w] & ~off) | (bus & off);
        assign sel = fld | SEL_LOW;
        assign tbm = ~((fld >> PTE_SHR) | TBL_LOW);
        assign pte_v[w] = (xbase[w] & tbm) | ((bus & sel) >> PTE_SHR);
    end

    always_comb begin
        hit      = 1'b0;
        win      = '0;
        sg       = 1'b0;
        dir_addr = '0;
        pte_addr = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_v[w]) begin
                hit      = 1'b1;
                win      = IW'(w);
                sg       = base[w][SG_BIT];
                dir_addr = dir_v[w];
                pte_addr = pte_v[w];
            end
        end
    end

endmodule

// File: rtl/dma_window_xlat.sv
module dma_window_xlat
    import dwx_pkg::*;
#(
    parameter int NWIN  = 4,
    parameter int AW    = 64,
    parameter int DW    = 64,
    parameter int OUT_W = 34
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr_en,
    input  logic [$clog2(NWIN)+1:0]    reg_addr,
    input  logic [AW-1:0]              reg_wdata,
    output logic [AW-1:0]              reg_rdata,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [AW-1:0]              req_addr,
    output logic                       rsp_valid,
    output logic [AW-1:0]              rsp_addr,
    output logic                       rsp_hit,
    output logic [$clog2(NWIN)-1:0]    rsp_win,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic [AW-1:0]              mem_req_addr,
    input  logic                       mem_rsp_valid,
    input  logic [DW-1:0]              mem_rsp_data
);

    localparam int IW = $clog2(NWIN);
    localparam logic [AW-1:0] KEEP = {{(AW-OUT_W){1'b0}}, {OUT_W{1'b1}}};

    typedef struct packed {
        xlat_st_e              st;
        logic                  rsp_v;
        logic [AW-1:0]         rsp_a;
        logic                  rsp_hit;
        logic [IW-1:0]         rsp_w;
        logic [AW-1:0]         mem_a;
        logic [PAGE_LSB-1:0]   low;
        logic [IW-1:0]         win;
    } state_t;

    state_t s_d, s_q;

    logic [NWIN-1:0][AW-1:0] w_base, w_mask, w_xbase;
    logic                    m_hit, m_sg;
    logic [IW-1:0]           m_win;
    logic [AW-1:0]           m_dir, m_pte;
    logic [AW-1:0]           frame;

    dwx_regfile #(.NWIN(NWIN), .AW(AW), .IW(IW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .base_o  (w_base),
        .mask_o  (w_mask),
        .xbase_o (w_xbase)
    );

    dwx_match #(.NWIN(NWIN), .AW(AW), .IW(IW)) u_match (
        .bus      (req_addr),
        .base     (w_base),
        .mask     (w_mask),
        .xbase    (w_xbase),
        .hit      (m_hit),
        .win      (m_win),
        .sg       (m_sg),
        .dir_addr (m_dir),
        .pte_addr (m_pte)
    );

    assign frame = AW'({mem_rsp_data[DW-1:1], 1'b0}) << FRAME_SHL;

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (m_hit && m_sg) begin
                        s_d.st    = ST_FETCH;
                        s_d.mem_a = m_pte;
                        s_d.low   = req_addr[PAGE_LSB-1:0];
                        s_d.win   = m_win;
                    end else begin
                        s_d.rsp_v   = 1'b1;
                        s_d.rsp_hit = m_hit;
                        s_d.rsp_w   = m_hit ? m_win : '0;
                        s_d.rsp_a   = m_hit ? (m_dir & KEEP) : req_addr;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    s_d.st      = ST_IDLE;
                    s_d.rsp_v   = 1'b1;
                    s_d.rsp_hit = 1'b1;
                    s_d.rsp_w   = s_q.win;
                    s_d.rsp_a   = (frame | AW'(s_q.low)) & KEEP;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready     = (s_q.st == ST_IDLE);
    assign mem_req_valid = (s_q.st == ST_FETCH);
    assign mem_req_addr  = s_q.mem_a;
    assign rsp_valid     = s_q.rsp_v;
    assign rsp_addr      = s_q.rsp_a;
    assign rsp_hit       = s_q.rsp_hit;
    assign rsp_win       = s_q.rsp_w;

endmodule

// File: rtl/dwx_chk.sv
module dwx_chk #(
    parameter int AW    = 64,
    parameter int OUT_W = 34
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          rsp_valid,
    input logic [AW-1:0] rsp_addr,
    input logic          rsp_hit,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr
);

    logic [AW-1:0] last_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      last_acc <= '0;
        else if (req_valid && req_ready) last_acc <= req_addr;
    end

    // R10: an accepted request either answers next cycle or starts a fetch
    assert_accept_progress_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || mem_req_valid));

    // R11: no response while the fetch request is pending
    assert_no_early_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rsp_valid);

    // R13: fetch request held steady until accepted
    assert_fetch_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8: hit results fit in OUT_W bits
    assert_hit_truncated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_addr[AW-1:OUT_W] == '0));

    // R9: a miss passes the accepted address through untouched
    assert_miss_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == last_acc));

endmodule

bind dma_window_xlat dwx_chk #(.AW(AW), .OUT_W(OUT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_addr      (rsp_addr),
    .rsp_hit       (rsp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/sim_dma_window_xlat.sv
module sim_dma_window_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic        rsp_hit;
    logic [1:0]  rsp_win;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] cfg_b [4];
    logic [63:0] cfg_m [4];
    logic [63:0] cfg_x [4];

    always #4 clk = ~clk;

    dma_window_xlat u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .rsp_valid     (rsp_valid),
        .rsp_addr      (rsp_addr),
        .rsp_hit       (rsp_hit),
        .rsp_win       (rsp_win),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ent(input logic [63:0] p);
        return {p[31:0], ~p[31:0]} ^ 64'h0123_4567_89AB_CDEF;
    endfunction

    function automatic void model(input logic [63:0] a, output bit hit, output int win,
                                  output bit sg, output logic [63:0] res, output logic [63:0] pte);
        logic [63:0] f, c, o;
        hit = 0; win = 0; sg = 0; res = a; pte = '0;
        for (int w = 3; w >= 0; w--) begin
            f = cfg_m[w] & 64'hFFF0_0000;
            c = ~cfg_m[w] & 64'hFFF0_0000;
            if (cfg_b[w][0] && ((a & c) == (cfg_b[w] & c))) begin
                hit = 1; win = w; sg = cfg_b[w][1];
                o   = f | 64'hF_FFFF;
                res = ((cfg_x[w] & ~o) | (a & o)) & 64'h3_FFFF_FFFF;
                pte = (cfg_x[w] & ~((f >> 10) | 64'h3FF)) | ((a & (f | (64'h7F << 13))) >> 10);
                if (sg) res = (((ent(pte) & ~64'h1) << 12) | (a & 64'h1FFF)) & 64'h3_FFFF_FFFF;
            end
        end
    endfunction

    task automatic wr(input logic [3:0] ad, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = ad; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] ad, input logic [63:0] exp, input string tag);
        @(negedge clk);
        reg_addr = ad;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic setwin(input int w, input logic [63:0] b, input logic [63:0] m, input logic [63:0] x);
        wr({2'd0, w[1:0]}, b); cfg_b[w] = b;
        wr({2'd1, w[1:0]}, m); cfg_m[w] = m;
        wr({2'd2, w[1:0]}, x); cfg_x[w] = x;
        rd_chk({2'd0, w[1:0]}, b, "R2 base readback");
        rd_chk({2'd1, w[1:0]}, m, "R2 mask readback");
        rd_chk({2'd2, w[1:0]}, x, "R2 xbase readback");
    endtask

    task automatic xlat(input logic [63:0] a, input bit poke);
        bit eh, esg;
        int ew;
        logic [63:0] er, ep, held;
        model(a, eh, ew, esg, er, ep);
        @(negedge clk);
        chk(req_ready === 1'b1, "R11 ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!esg) begin
            chk(rsp_valid === 1'b1, "R10 one-cycle response", 64'(rsp_valid), 64'd1);
        end else begin
            chk(mem_req_valid === 1'b1 && rsp_valid === 1'b0, "R11 fetch issued, no response",
                64'({mem_req_valid, rsp_valid}), 64'b10);
            chk(mem_req_addr === ep, "R6 entry address", mem_req_addr, ep);
            held = mem_req_addr;
            if (poke) begin
                reg_wr_en = 1'b1; reg_addr = {2'd2, ew[1:0]}; reg_wdata = 64'h0000_0000_0ABC_0000;
                cfg_x[ew] = 64'h0000_0000_0ABC_0000;
            end
            @(negedge clk);
            reg_wr_en = 1'b0;
            chk(mem_req_valid === 1'b1 && mem_req_addr === held, "R13 request held", mem_req_addr, held);
            chk(req_ready === 1'b0, "R11 busy during fetch", 64'(req_ready), 64'd0);
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R11 waiting for data",
                64'({req_ready, rsp_valid}), 64'd0);
            mem_rsp_valid = 1'b1; mem_rsp_data = ent(ep);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(rsp_valid === 1'b1, "R11 response after data", 64'(rsp_valid), 64'd1);
        end
        chk(rsp_hit === eh, "R3 hit flag", 64'(rsp_hit), 64'(eh));
        chk(rsp_win === 2'(ew), "R4 window index", 64'(rsp_win), 64'(ew));
        if (!eh)       chk(rsp_addr === er, "R9 miss passthrough", rsp_addr, er);
        else if (esg)  chk(rsp_addr === er, "R7 scatter-gather result", rsp_addr, er);
        else           chk(rsp_addr === er, "R5 direct result", rsp_addr, er);
        if (eh) chk(rsp_addr[63:34] === '0, "R8 truncation", rsp_addr, er);
    endtask

    task automatic sweep();
        logic [63:0] a;
        for (int t = 0; t < 4096; t++) begin
            a = {$urandom(), t[11:0], 20'($urandom())};
            xlat(a, 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234));
        for (int w = 0; w < 4; w++) begin
            cfg_b[w] = '0; cfg_m[w] = '0; cfg_x[w] = '0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
            "R1 outputs in reset", 64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset
        for (int k = 0; k < 12; k++) rd_chk(4'(k), 64'd0, "R1 register reset value");

        // R9: nothing enabled, full address passes through
        xlat(64'hFEDC_BA98_7654_3210, 1'b0);

        // R2: kind 3 ignores writes and reads zero
        wr(4'b1101, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk(4'b1101, 64'd0, "R2 unused kind reads zero");
        rd_chk(4'b0001, 64'd0, "R2 unused kind write left window base intact");

        // Layout A: direct w0, SG w1, disabled w2, w3 shadowed by w0
        setwin(0, 64'h0000_0000_4000_0001, 64'h0000_0000_0FF0_0000, 64'hFFFF_FFF3_8000_0000);
        setwin(1, 64'h0000_0000_8000_0003, 64'h0000_0000_0030_0000, 64'h0000_0000_0012_3000);
        setwin(2, 64'h0000_0000_C000_0000, 64'h0000_0000_3FF0_0000, 64'h0000_0000_5500_0000);
        setwin(3, 64'h0000_0000_4400_0001, 64'h0000_0000_00F0_0000, 64'h0000_0002_0000_0000);
        sweep();

        // R12: rewrite the SG window's table base during its own fetch
        xlat(64'h0000_0007_8012_3456, 1'b1);
        rd_chk(4'b1001, 64'h0000_0000_0ABC_0000, "R12 write landed");
        xlat(64'h0000_0007_8012_3456, 1'b0);

        // Layout B: w0 disabled exposes w3; w1 direct; w2 SG with wide mask
        setwin(0, 64'h0000_0000_4000_0000, 64'h0000_0000_0FF0_0000, 64'hFFFF_FFF3_8000_0000);
        setwin(1, 64'h0000_0000_8000_0001, 64'h0000_0000_0030_0000, 64'h0000_0001_2340_0000);
        setwin(2, 64'h0000_0000_C000_0003, 64'h0000_0000_3FF0_0000, 64'hFFFF_0000_00F0_0000);
        setwin(3, 64'h0000_0000_4400_0001, 64'h0000_0000_00F0_0000, 64'h0000_0002_FFF0_0000);
        sweep();

        finish_run();
    end

endmodule